// File: doc/BRIEF.md
# Half-Bridge Adaptive Dead-Time Controller

This block generates the high-side and low-side gate commands for a resonant half-bridge. The commands are built from two sources. The first is a digital oscillator, which sends an end-of-ramp pulse once per oscillator cycle and an upper-level pulse. The second is a slope sensor on the half-bridge node, which reports when the node starts to move and when it has finished moving. The oscillator runs at twice the half-bridge frequency. Each end-of-ramp pulse switches off the conducting side, and the next conduction goes to the other side.

The dead time after each turn-off is not fixed. The opposite switch turns on as soon as the node transition is complete. It never turns on before a minimum number of dead cycles. If the node is still moving when the oscillator charge phase ends, the switch is forced on. If the node has not started moving at all (capacitive mode), the block keeps waiting until the oscillator reaches its upper level. From turn-off until the slope is seen to start, the block asks the oscillator to use a reduced charge rate.

A burst request holds both gates off. Switching then resumes at the first end-of-ramp after the request is released, with no soft start. A boost-undervoltage stop or a disable lets switching run on until the next low-side turn-on. From that point the low side is held on.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `gate_hs_o` and `gate_ls_o` are never high in the same cycle.
- R2: While reset is asserted and right after it, `gate_ls_o` is 1, `gate_hs_o` is 0 and `slow_charge_o` is 0.
- R3: While running (`en_i`=1, `stop_i`=0), an `osc_eor_i` pulse sampled while a gate is on clears that gate in the next cycle. The next gate to turn on is the opposite side, so sides alternate on successive oscillator cycles.
- R4: Dead cycles are the cycles after turn-off in which both gates are low. A `slope_end_i` pulse seen in dead cycle d turns the opposite gate on after dead cycle max(d, MIN_DT). No gate ever turns on with fewer than MIN_DT dead cycles before it.
- R5: If `slope_start_i` has been seen but no `slope_end_i` by dead cycle PHASE_CYC, the opposite gate is forced on after dead cycle max(PHASE_CYC, MIN_DT).
- R6: If no `slope_start_i` has been seen (capacitive mode), the block waits beyond PHASE_CYC. It forces turn-on after dead cycle max(t, MIN_DT), where t is the dead cycle in which `osc_top_i` is first seen.
- R7: `slow_charge_o` is 1 from the first dead cycle through the cycle in which `slope_start_i` is first sampled. It is 0 from the following cycle on, and whenever a gate is on.
- R8: While running, `burst_i`=1 drives both gates low in the next cycle. `osc_eor_i` has no effect while the burst request is held. After release, the first `osc_eor_i` turns `gate_ls_o` on directly in the next cycle.
- R9: On `stop_i`=1 or `en_i`=0, a conducting high side still completes its cycle, and the low side turns on after the usual dead time. Once the low side is on, it stays on and `osc_eor_i` is ignored.
- R10: When run conditions return, the next `osc_eor_i` resumes normal alternation: the low side turns off and the high side follows after the adaptive dead time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; 0 stops at the next low-side turn-on and holds the low side on |
| stop_i | input | 1 | Boost undervoltage stop; same stopping behaviour as disable |
| burst_i | input | 1 | Burst pause request; both gates off while high |
| osc_eor_i | input | 1 | Oscillator end-of-ramp pulse, one cycle |
| osc_top_i | input | 1 | Oscillator upper-level pulse, one cycle |
| slope_start_i | input | 1 | Half-bridge slope has started, pulse |
| slope_end_i | input | 1 | Half-bridge slope has ended, pulse |
| gate_hs_o | output | 1 | High-side gate command |
| gate_ls_o | output | 1 | Low-side gate command |
| slow_charge_o | output | 1 | Reduced oscillator charge-rate request |

## Verification
The functions most likely to meet in one cycle are the minimum dead-time bound and an adaptive turn-on trigger. Either a slope-end pulse or an oscillator upper-level pulse can arrive during the first dead cycles, before the minimum has elapsed. Directed runs place these pulses in dead cycles 1 through MIN_DT. Seeded random runs place start, end and upper-level pulses at arbitrary offsets. A bench function derives the expected dead-cycle count from the rules, and the measured count must match it exactly. A second overlap occurs when a burst request or a stop arrives while a dead interval is pending. This is judged by which gate, if any, rises afterwards.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;
  typedef enum logic [1:0] {
    ST_ON    = 2'd0,
    ST_DEAD  = 2'd1,
    ST_PAUSE = 2'd2
  } hb_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic top;
  } slope_ev_t;
endpackage

// File: rtl/hb_dt_timer.sv
module hb_dt_timer #(
  parameter int MIN_DT    = 4,
  parameter int PHASE_CYC = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  hb_dt_pkg::slope_ev_t  ev_i,
  output logic                  dt_ok_o,
  output logic                  on_req_o,
  output logic                  start_seen_o
);
  localparam int CNT_MAX = (MIN_DT > PHASE_CYC) ? MIN_DT : PHASE_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] DT_LIM = CW'(MIN_DT - 1);
  localparam logic [CW-1:0] PH_LIM = CW'(PHASE_CYC - 1);
  localparam logic [CW-1:0] SAT    = CW'(CNT_MAX);

  logic [CW-1:0] cnt_q;
  hb_dt_pkg::slope_ev_t seen_q, eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      seen_q <= '0;
    end else begin
      if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      seen_q <= seen_q | ev_i;
    end
  end

  assign eff          = seen_q | ev_i;
  assign dt_ok_o      = (cnt_q >= DT_LIM);
  assign start_seen_o = seen_q.start;

  // turn-on request for the current dead cycle (cnt_q + 1)
  always_comb begin
    on_req_o = 1'b0;
    if (!clr_i && dt_ok_o) begin
      if (eff.stop)                                on_req_o = 1'b1;
      else if (eff.start && (cnt_q >= PH_LIM))     on_req_o = 1'b1;
      else if (!eff.start && eff.top)              on_req_o = 1'b1;
    end
  end
endmodule

// File: rtl/hb_dt_fsm.sv
module hb_dt_fsm (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic                 burst_i,
  input  logic                 osc_eor_i,
  input  logic                 on_req_i,
  input  logic                 dt_ok_i,
  output hb_dt_pkg::hb_state_e state_o,
  output logic                 side_hs_o
);
  import hb_dt_pkg::*;

  hb_state_e state_q, state_d;
  logic      side_q, side_d;
  logic      pause_req;

  assign pause_req = burst_i && run_i;

  always_comb begin
    state_d = state_q;
    side_d  = side_q;
    unique case (state_q)
      ST_ON: begin
        if (pause_req) begin
          state_d = ST_PAUSE;
        end else if (osc_eor_i && (run_i || side_q)) begin
          state_d = ST_DEAD;
          side_d  = !side_q;
        end
      end
      ST_DEAD: begin
        if (pause_req)     state_d = ST_PAUSE;
        else if (on_req_i) state_d = ST_ON;
      end
      ST_PAUSE: begin
        if (dt_ok_i && (!run_i || (!burst_i && osc_eor_i))) begin
          state_d = ST_ON;
          side_d  = 1'b0;
        end
      end
      default: begin
        state_d = ST_ON;
        side_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ON;
      side_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      side_q  <= side_d;
    end
  end

  assign state_o   = state_q;
  assign side_hs_o = side_q;
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl #(
  parameter int MIN_DT    = 4,
  parameter int PHASE_CYC = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stop_i,
  input  logic burst_i,
  input  logic osc_eor_i,
  input  logic osc_top_i,
  input  logic slope_start_i,
  input  logic slope_end_i,
  output logic gate_hs_o,
  output logic gate_ls_o,
  output logic slow_charge_o
);
  import hb_dt_pkg::*;

  hb_state_e state;
  slope_ev_t ev;
  logic      side_hs, on_req, dt_ok, start_seen, run, conducting;

  assign run        = en_i && !stop_i;
  assign conducting = (state == ST_ON);
  assign ev         = '{start: slope_start_i, stop: slope_end_i, top: osc_top_i};

  hb_dt_timer #(.MIN_DT(MIN_DT), .PHASE_CYC(PHASE_CYC)) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (conducting),
    .ev_i         (ev),
    .dt_ok_o      (dt_ok),
    .on_req_o     (on_req),
    .start_seen_o (start_seen)
  );

  hb_dt_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .burst_i   (burst_i),
    .osc_eor_i (osc_eor_i),
    .on_req_i  (on_req),
    .dt_ok_i   (dt_ok),
    .state_o   (state),
    .side_hs_o (side_hs)
  );

  assign gate_hs_o     = conducting && side_hs;
  assign gate_ls_o     = conducting && !side_hs;
  assign slow_charge_o = (state == ST_DEAD) && !start_seen;
endmodule

// File: rtl/hb_dt_checker.sv
module hb_dt_checker #(
  parameter int MIN_DT = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic stop_i,
  input logic burst_i,
  input logic gate_hs_o,
  input logic gate_ls_o,
  input logic slow_charge_o
);
  localparam int OW = $clog2(MIN_DT + 1) + 1;
  logic [OW-1:0] off_cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt_q <= '0;
      armed_q   <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (gate_hs_o || gate_ls_o)        off_cnt_q <= '0;
      else if (off_cnt_q < OW'(MIN_DT))  off_cnt_q <= off_cnt_q + 1'b1;
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_hs_o && gate_ls_o));

  p_min_dead_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && ($rose(gate_hs_o) || $rose(gate_ls_o))) |-> (off_cnt_q >= OW'(MIN_DT)));

  p_slow_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_hs_o || gate_ls_o) |-> !slow_charge_o);

  p_burst_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && en_i && !stop_i) |=> (!gate_hs_o && !gate_ls_o));

  p_hold_ls_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_ls_o && (!en_i || stop_i)) |=> gate_ls_o);
endmodule

bind hb_deadtime_ctrl hb_dt_checker #(.MIN_DT(MIN_DT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .stop_i        (stop_i),
  .burst_i       (burst_i),
  .gate_hs_o     (gate_hs_o),
  .gate_ls_o     (gate_ls_o),
  .slow_charge_o (slow_charge_o)
);

// File: tb/sim_hb_deadtime_ctrl.sv
`timescale 1ns/1ps
module sim_hb_deadtime_ctrl;
  localparam int MIN_DT = 4;
  localparam int PHASE  = 24;
  localparam int LIM    = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, stop = 1'b0, burst = 1'b0;
  logic eor = 1'b0, top = 1'b0, s_start = 1'b0, s_end = 1'b0;
  logic ghs, gls, slow;
  int   n_chk = 0, n_fail = 0;
  logic exp_hs = 1'b0;

  always #5 clk = ~clk;

  hb_deadtime_ctrl #(.MIN_DT(MIN_DT), .PHASE_CYC(PHASE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .stop_i(stop), .burst_i(burst),
    .osc_eor_i(eor), .osc_top_i(top), .slope_start_i(s_start), .slope_end_i(s_end),
    .gate_hs_o(ghs), .gate_ls_o(gls), .slow_charge_o(slow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected dead-cycle count from R4, R5, R6 (0 = event absent)
  function automatic int exp_dead(input int s, input int e, input int t);
    for (int d = 1; d <= LIM; d++) begin
      bit st = (s > 0) && (s <= d);
      bit en_ = (e > 0) && (e <= d);
      bit tp = (t > 0) && (t <= d);
      if (d >= MIN_DT && (en_ || (st && d >= PHASE) || (!st && tp))) return d;
    end
    return -1;
  endfunction

  task automatic dead_run(input int s, input int e, input int t, input string tag);
    int meas = -1;
    @(negedge clk); eor = 1'b1;
    @(negedge clk); eor = 1'b0;
    check(!ghs && !gls, "R3 gate off after end-of-ramp", {ghs, gls}, 0);
    for (int d = 1; d <= LIM; d++) begin
      check(slow == !((s > 0) && (s <= d - 1)), "R7 slow charge", slow, !((s > 0) && (s <= d - 1)));
      s_start = (d == s); s_end = (d == e); top = (d == t);
      @(negedge clk);
      if (ghs || gls) begin meas = d; break; end
    end
    s_start = 1'b0; s_end = 1'b0; top = 1'b0;
    exp_hs = !exp_hs;
    check(meas == exp_dead(s, e, t), tag, meas, exp_dead(s, e, t));
    check(ghs == exp_hs && gls == !exp_hs, "R3 side alternation", ghs, exp_hs);
  endtask

  task automatic pulse_eor();
    @(negedge clk); eor = 1'b1;
    @(negedge clk); eor = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    check(gls && !ghs && !slow, "R2 reset state", {ghs, gls, slow}, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(gls && !ghs && !slow, "R2 after reset", {ghs, gls, slow}, 1);

    // directed corner cases
    dead_run(0, 1, 0, "R4 end before minimum");
    dead_run(1, MIN_DT, 0, "R4 end at minimum");
    dead_run(2, 10, 0, "R4 end adaptive");
    dead_run(2, 0, 0, "R5 forced at charge phase end");
    dead_run(3, 0, 6, "R5 top ignored once slope started");
    dead_run(0, 0, 2, "R6 capacitive top before minimum");
    dead_run(0, 0, 50, "R6 capacitive waits past phase");
    dead_run(30, 0, 0, "R5 late start forced");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int s = $urandom % 30;
      int e = ($urandom % 3 == 0) ? 0 : s + ($urandom % 30);
      int t = $urandom % 60;
      if (s == 0 && e == 0 && t == 0) t = 7;
      dead_run(s, e, t, "R4 R5 R6 random");
    end

    // stop: high side finishes, low side then held (R9), resume (R10)
    if (!exp_hs) dead_run(0, 6, 0, "R4 setup");
    stop = 1'b1;
    dead_run(0, 6, 0, "R9 stop lets high side finish");
    for (int k = 0; k < 3; k++) begin
      pulse_eor();
      check(gls && !ghs, "R9 low side held under stop", {ghs, gls}, 1);
    end
    stop = 1'b0;
    dead_run(1, 5, 0, "R10 resume after stop");
    dead_run(0, 5, 0, "R4 back to low side");
    en = 1'b0;
    repeat (2) begin
      pulse_eor();
      check(gls && !ghs, "R9 low side held when disabled", {ghs, gls}, 1);
    end
    burst = 1'b1;
    @(negedge clk);
    check(gls && !ghs, "R9 burst ignored when disabled", {ghs, gls}, 1);
    burst = 1'b0;
    en = 1'b1;
    dead_run(0, 8, 0, "R10 resume after enable");

    // burst with high side on
    burst = 1'b1;
    @(negedge clk);
    check(!ghs && !gls, "R8 burst clears gates", {ghs, gls}, 0);
    pulse_eor();
    check(!ghs && !gls, "R8 end-of-ramp ignored in burst", {ghs, gls}, 0);
    burst = 1'b0;
    repeat (2) @(negedge clk);
    check(!ghs && !gls, "R8 waits for end-of-ramp", {ghs, gls}, 0);
    pulse_eor();
    check(gls && !ghs, "R8 resume on low side", {ghs, gls}, 1);
    exp_hs = 1'b0;
    dead_run(2, 9, 0, "R3 alternation after burst");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule